// File: doc/BRIEF.md
# Impulse Noise Blanking Pulse Former

This block watches a digitized FM multiplex stream for short ignition-type spikes and answers each one with a blanking pulse. The downstream audio path uses that pulse to freeze on its last good value. Each clock cycle it receives three values: the rectified magnitude of the high-passed sample, a smoothed peak estimate of the noise floor, and an optional offset. The offset is how external deviation or field-strength detectors push the peak estimate upward.

The trigger threshold sits on top of the peak estimate. On a clean signal it is a fixed low value chosen by a 3-bit code. Once the peak estimate climbs above a knee, a noise-controlled term takes over. That term is a code-selected slope times the excess of the peak over the knee. A trigger starts a retriggerable one-shot, and the one-shot's length comes from a 2-bit blank-time code. The active-low hold strobe stays low while the one-shot runs. A saturating trigger counter is provided for debug. An enable input switches the whole function off.

All values share one unsigned scale: one LSB equals `LSB_UV` microvolts, which is 1 mV by default. Durations are converted to clock cycles from `CLK_HZ` and rounded to the nearest cycle.

Top module: `nb_pulse_former`

## Requirements
- R1: While reset is applied, and directly after it, `holdN` is 1 and `trigCount` is 0.
- R2: The effective peak is `peakEst + peakOfs`, saturated at the full-scale value. A trigger occurs in a cycle when `blankEn` is 1 and `rectMag` is strictly greater than the effective peak plus the threshold. The low threshold is (65 − 5·`lowThrCode`) mV, so code 0 gives 65 mV and code 7 gives 30 mV.
- R3: The knee is 900 mV. When the effective peak exceeds the knee, a noise term equals ((peak − knee) · S) >> 8, where S = round(256·L/600) and L is 260, 220, 180 or 140 for `noiseThrCode` 0, 1, 2 or 3. The threshold is the larger of the noise term and the low threshold. At or below the knee, only the low threshold applies.
- R4: A `peakOfs` that drives the effective peak past full scale saturates the sum instead of wrapping it.
- R5: `blankTimeCode` 0, 1, 2 or 3 selects 38, 25.5, 32 or 22 µs; that order is fixed. With N = round(time·`CLK_HZ`), a trigger sampled at a clock edge drives `holdN` low from that edge for exactly N cycles.
- R6: A trigger during a running pulse reloads the full count, using the code present at the retrigger.
- R7: A trigger on the last low cycle of a pulse keeps `holdN` low with no high gap.
- R8: While `blankEn` is 0, `holdN` is 1 from the next edge on and any running pulse is cancelled. Triggers are neither acted on nor counted while `blankEn` is 0.
- R9: `trigCount` rises by one for every enabled trigger cycle and saturates at all-ones.
- R10: A change of `blankTimeCode` during a pulse does not alter the length of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| blankEn | input | 1 | Enables the blanker |
| rectMag | input | SAMPLE_W | Rectified high-pass sample magnitude |
| peakEst | input | SAMPLE_W | Smoothed peak estimate |
| peakOfs | input | SAMPLE_W | Offset added to the peak by external detectors |
| lowThrCode | input | 3 | Low threshold select |
| noiseThrCode | input | 2 | Noise-controlled slope select |
| blankTimeCode | input | 2 | Hold duration select |
| holdN | output | 1 | Active-low hold strobe |
| trigCount | output | TRIG_CNT_W | Saturating trigger count |

## Verification
A wrong threshold shows up in the very next cycle: a sample one LSB below or one LSB above the computed level produces the wrong `holdN` edge and the wrong `trigCount` step. A corrupted hold counter or a mis-latched duration code stays invisible until the pulse should end. It then appears as a `holdN` release that comes too early, too late, or with a gap, up to 1900 cycles after the trigger at the default clock. The bench therefore predicts `holdN` and `trigCount` for every cycle, so a timing slip is caught on the exact cycle where it happens.

// File: rtl/nbpf_pkg.sv
package nbpf_pkg;

  // strobes issued by the control toward the datapath
  typedef struct packed {
    logic load;   // start or restart the hold counter
    logic dec;    // count one cycle of hold down
    logic clr;    // abandon any running pulse
    logic bump;   // advance the trigger counter
  } nbStrobe_t;

  localparam longint KNEE_UV   = 900_000;
  localparam longint REFPK_UV  = 1_500_000;

  function automatic longint lowThrUv(input int code);
    return 65_000 - 5_000 * longint'(code);
  endfunction

  function automatic longint noiseLvlUv(input int code);
    return 260_000 - 40_000 * longint'(code);
  endfunction

  function automatic longint blankNs(input int code);
    case (code)
      0:       return 38_000;
      1:       return 25_500;
      2:       return 32_000;
      default: return 22_000;
    endcase
  endfunction

  function automatic longint blankCycles(input int code, input longint clkHz);
    return (blankNs(code) * clkHz + 64'd500_000_000) / 64'd1_000_000_000;
  endfunction

  function automatic longint maxBlankCycles(input longint clkHz);
    longint m = 0;
    for (int c = 0; c < 4; c++)
      if (blankCycles(c, clkHz) > m) m = blankCycles(c, clkHz);
    return m;
  endfunction

  // slope in Q8: round(256 * level / span)
  function automatic longint slopeQ8(input int code);
    longint span = REFPK_UV - KNEE_UV;
    return (256 * noiseLvlUv(code) + span / 2) / span;
  endfunction

endpackage

// File: rtl/nbpf_thresh.sv
module nbpf_thresh
  import nbpf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LSB_UV   = 1000
) (
  input  logic [SAMPLE_W-1:0] peakEff,
  input  logic [2:0]          lowThrCode,
  input  logic [1:0]          noiseThrCode,
  output logic [SAMPLE_W-1:0] thr
);
  localparam int SLOPE_W = 8;
  localparam int PROD_W  = SAMPLE_W + SLOPE_W;
  localparam longint KNEE_L = (KNEE_UV + LSB_UV / 2) / LSB_UV;
  localparam logic [SAMPLE_W-1:0] KNEE = SAMPLE_W'(KNEE_L);

  logic [SAMPLE_W-1:0] lowTab   [8];
  logic [SLOPE_W-1:0]  slopeTab [4];

  for (genvar g = 0; g < 8; g++) begin : gLow
    assign lowTab[g] = SAMPLE_W'((lowThrUv(g) + LSB_UV / 2) / LSB_UV);
  end

  for (genvar g = 0; g < 4; g++) begin : gSlope
    assign slopeTab[g] = SLOPE_W'(slopeQ8(g));
  end

  logic [SAMPLE_W-1:0] lowSel;
  logic [SAMPLE_W-1:0] excess;
  logic [PROD_W-1:0]   prod;
  logic [SAMPLE_W-1:0] noiseTerm;

  always_comb begin
    lowSel    = lowTab[lowThrCode];
    excess    = (peakEff > KNEE) ? (peakEff - KNEE) : '0;
    prod      = PROD_W'(excess) * PROD_W'(slopeTab[noiseThrCode]);
    noiseTerm = prod[PROD_W-1:SLOPE_W];
    thr       = (noiseTerm > lowSel) ? noiseTerm : lowSel;
  end

endmodule

// File: rtl/nbpf_datapath.sv
module nbpf_datapath
  import nbpf_pkg::*;
#(
  parameter int     SAMPLE_W   = 12,
  parameter int     LSB_UV     = 1000,
  parameter longint CLK_HZ     = 50_000_000,
  parameter int     TRIG_CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SAMPLE_W-1:0]   rectMag,
  input  logic [SAMPLE_W-1:0]   peakEst,
  input  logic [SAMPLE_W-1:0]   peakOfs,
  input  logic [2:0]            lowThrCode,
  input  logic [1:0]            noiseThrCode,
  input  logic [1:0]            blankTimeCode,
  input  nbStrobe_t             stb,
  output logic                  trig,
  output logic                  cntZero,
  output logic [TRIG_CNT_W-1:0] trigCount
);
  localparam longint MAXN = maxBlankCycles(CLK_HZ);
  localparam int     HW   = $clog2(MAXN + 1);
  localparam int     CW   = SAMPLE_W + 1;

  // effective peak with saturation
  logic [CW-1:0]       peakSum;
  logic [SAMPLE_W-1:0] peakEff;
  logic [SAMPLE_W-1:0] thr;
  logic [CW-1:0]       level;

  always_comb begin
    peakSum = CW'(peakEst) + CW'(peakOfs);
    peakEff = peakSum[CW-1] ? '1 : peakSum[SAMPLE_W-1:0];
  end

  nbpf_thresh #(.SAMPLE_W(SAMPLE_W), .LSB_UV(LSB_UV)) uThr (
    .peakEff      (peakEff),
    .lowThrCode   (lowThrCode),
    .noiseThrCode (noiseThrCode),
    .thr          (thr)
  );

  always_comb begin
    level = CW'(peakEff) + CW'(thr);
    trig  = CW'(rectMag) > level;
  end

  // hold length per code
  logic [HW-1:0] loadTab [4];
  for (genvar g = 0; g < 4; g++) begin : gLen
    assign loadTab[g] = HW'(blankCycles(g, CLK_HZ) - 1);
  end

  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst || stb.clr)      holdCnt <= '0;
    else if (stb.load)       holdCnt <= loadTab[blankTimeCode];
    else if (stb.dec)        holdCnt <= holdCnt - 1'b1;
  end

  assign cntZero = (holdCnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                          trigCount <= '0;
    else if (stb.bump && !(&trigCount)) trigCount <= trigCount + 1'b1;
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    holdCnt < HW'(MAXN));

  assert_trig_step_R9: assert property (@(posedge clk) disable iff (rst)
    (trigCount == $past(trigCount)) || (trigCount == $past(trigCount) + 1'b1));

  assert_trig_sat_R9: assert property (@(posedge clk) disable iff (rst)
    (&$past(trigCount)) |-> (&trigCount));

  assert_trig_above_peak_R2: assert property (@(posedge clk) disable iff (rst)
    trig |-> (rectMag > peakEff));

endmodule

// File: rtl/nbpf_ctrl.sv
module nbpf_ctrl
  import nbpf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      blankEn,
  input  logic      trig,
  input  logic      cntZero,
  output nbStrobe_t stb,
  output logic      holdN
);
  logic holding;
  logic holdingNext;

  always_comb begin
    stb      = '0;
    stb.bump = blankEn && trig;
    if (!blankEn)                  stb.clr  = 1'b1;
    else if (trig)                 stb.load = 1'b1;
    else if (holding && !cntZero)  stb.dec  = 1'b1;

    if (!blankEn)                  holdingNext = 1'b0;
    else if (trig)                 holdingNext = 1'b1;
    else if (holding && cntZero)   holdingNext = 1'b0;
    else                           holdingNext = holding;
  end

  always_ff @(posedge clk) begin
    if (rst) holding <= 1'b0;
    else     holding <= holdingNext;
  end

  assign holdN = !holding;

  assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !blankEn |=> holdN);

  assert_trig_starts_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (blankEn && trig) |=> !holdN);

  assert_release_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(holdN) |-> ($past(cntZero) || !$past(blankEn)));

endmodule

// File: rtl/nb_pulse_former.sv
module nb_pulse_former
  import nbpf_pkg::*;
#(
  parameter int     SAMPLE_W   = 12,
  parameter int     LSB_UV     = 1000,
  parameter longint CLK_HZ     = 50_000_000,
  parameter int     TRIG_CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  blankEn,
  input  logic [SAMPLE_W-1:0]   rectMag,
  input  logic [SAMPLE_W-1:0]   peakEst,
  input  logic [SAMPLE_W-1:0]   peakOfs,
  input  logic [2:0]            lowThrCode,
  input  logic [1:0]            noiseThrCode,
  input  logic [1:0]            blankTimeCode,
  output logic                  holdN,
  output logic [TRIG_CNT_W-1:0] trigCount
);
  nbStrobe_t stb;
  logic      trig;
  logic      cntZero;

  nbpf_datapath #(
    .SAMPLE_W(SAMPLE_W), .LSB_UV(LSB_UV), .CLK_HZ(CLK_HZ), .TRIG_CNT_W(TRIG_CNT_W)
  ) uDp (
    .clk           (clk),
    .rst           (rst),
    .rectMag       (rectMag),
    .peakEst       (peakEst),
    .peakOfs       (peakOfs),
    .lowThrCode    (lowThrCode),
    .noiseThrCode  (noiseThrCode),
    .blankTimeCode (blankTimeCode),
    .stb           (stb),
    .trig          (trig),
    .cntZero       (cntZero),
    .trigCount     (trigCount)
  );

  nbpf_ctrl uCtl (
    .clk     (clk),
    .rst     (rst),
    .blankEn (blankEn),
    .trig    (trig),
    .cntZero (cntZero),
    .stb     (stb),
    .holdN   (holdN)
  );

endmodule

// File: tb/sim_nb_pulse_former.sv
module sim_nb_pulse_former;
  localparam int SW = 12;
  localparam int CW = 8;
  localparam int FULL = (1 << SW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          blankEn = 1'b0;
  logic [SW-1:0] rectMag = '0, peakEst = '0, peakOfs = '0;
  logic [2:0]    lowThrCode = '0;
  logic [1:0]    noiseThrCode = '0, blankTimeCode = '0;
  logic          holdN;
  logic [CW-1:0] trigCount;

  nb_pulse_former #(.SAMPLE_W(SW), .TRIG_CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .blankEn(blankEn), .rectMag(rectMag),
    .peakEst(peakEst), .peakOfs(peakOfs), .lowThrCode(lowThrCode),
    .noiseThrCode(noiseThrCode), .blankTimeCode(blankTimeCode),
    .holdN(holdN), .trigCount(trigCount)
  );

  typedef struct {
    int    stamp;
    logic  expHoldN;
    int    expCnt;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench-side stimulus settings and reference state
  int tPeak = 0, tOfs = 0, tLow = 0, tNc = 0, tBlk = 0;
  bit tEn = 0;
  int mRem = 0, mCnt = 0;

  function automatic int expThr(input int pe, input int lc, input int nc);
    int low   = 65 - 5 * lc;
    int lvl   = 260 - 40 * nc;
    int slope = (256 * lvl + 300) / 600;
    int noise = (pe > 900) ? (((pe - 900) * slope) >> 8) : 0;
    return (noise > low) ? noise : low;
  endfunction

  function automatic int holdLen(input int b);
    int ns;
    case (b)
      0: ns = 38000;
      1: ns = 25500;
      2: ns = 32000;
      default: ns = 22000;
    endcase
    return (ns * 50 + 500) / 1000;   // 50 MHz clock
  endfunction

  function automatic int peakEffOf();
    int pe = tPeak + tOfs;
    return (pe > FULL) ? FULL : pe;
  endfunction

  task automatic step(input int r, input string tag);
    item_t it;
    int pe;
    bit tr;
    @(posedge clk);
    #2;
    blankEn = tEn; rectMag = SW'(r); peakEst = SW'(tPeak); peakOfs = SW'(tOfs);
    lowThrCode = 3'(tLow); noiseThrCode = 2'(tNc); blankTimeCode = 2'(tBlk);
    pe = peakEffOf();
    tr = tEn && (r > pe + expThr(pe, tLow, tNc));
    if (!tEn) mRem = 0;
    else if (tr) begin
      mRem = holdLen(tBlk);
      if (mCnt < CMAX) mCnt++;
    end else if (mRem > 0) mRem--;
    it.stamp = cyc; it.expHoldN = (mRem == 0); it.expCnt = mCnt; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic runOut(input string tag);
    while (mRem > 0) step(0, tag);
    step(0, tag);
  endtask

  task automatic edgePair(input string tag);
    int t = peakEffOf() + expThr(peakEffOf(), tLow, tNc);
    step(t, tag);        // equal to threshold: no trigger
    step(t + 1, tag);    // one LSB above: trigger
    runOut(tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    item_t it;
    cyc++;
    #5;
    while (q.size() > 0 && q[0].stamp < cyc) begin
      it = q.pop_front();
      total++;
      if (holdN !== it.expHoldN || trigCount !== CW'(it.expCnt)) begin
        bad++;
        $display("FAIL %s cyc=%0d holdN=%b exp=%b trigCount=%0d exp=%0d",
                 it.tag, cyc, holdN, it.expHoldN, trigCount, it.expCnt);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (holdN !== 1'b1 || trigCount !== '0) begin
      bad++;
      $display("FAIL R1 reset holdN=%b exp=1 trigCount=%0d exp=0", holdN, trigCount);
    end
    @(posedge clk); #2; rst = 1'b0;
    step(0, "R1 after reset");

    tEn = 1; tPeak = 100; tOfs = 0; tLow = 0; tNc = 0; tBlk = 3;
    edgePair("R2 low code 0");
    tLow = 7;
    edgePair("R2 low code 7");
    tLow = 3;
    edgePair("R2 low code 3");

    tPeak = 1500; tNc = 0; tLow = 0;
    edgePair("R3 noise code 0");
    tNc = 3;
    edgePair("R3 noise code 3");
    tNc = 1; tPeak = 2500;
    edgePair("R3 noise code 1 high peak");
    tPeak = 900; tNc = 0;
    edgePair("R3 at knee low only");

    tPeak = 100; tOfs = 200; tLow = 0;
    edgePair("R4 offset added");
    tPeak = 4000; tOfs = 500;
    step(FULL, "R4 saturated peak no trigger");
    step(0, "R4 saturated peak no trigger");
    tOfs = 0; tPeak = 100;

    for (int b = 0; b < 4; b++) begin
      tBlk = b;
      step(1000, "R5 duration");
      runOut("R5 duration");
    end

    tBlk = 0;
    step(1000, "R6 first");
    repeat (500) step(0, "R6 running");
    tBlk = 2;
    step(1000, "R6 retrigger");
    runOut("R6 reload");

    tBlk = 3;
    step(1000, "R7 first");
    while (mRem > 1) step(0, "R7 running");
    step(1000, "R7 last-cycle retrigger");
    runOut("R7 no gap");

    tBlk = 1;
    step(1000, "R10 start");
    repeat (10) step(0, "R10 running");
    tBlk = 0;
    runOut("R10 code change ignored");

    tBlk = 3;
    step(1000, "R8 start");
    repeat (20) step(0, "R8 running");
    tEn = 0;
    step(0, "R8 disabled cancels");
    repeat (6) step(3000, "R8 triggers ignored");
    tEn = 1;
    step(0, "R8 re-enabled idle");

    repeat (300) step(4000, "R9 saturation");
    tEn = 0;
    step(0, "R9 end");
    step(0, "R9 end");

    @(posedge clk); @(posedge clk); #8;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule